// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Scheduler

This block decides when an SDR SDRAM must be refreshed and asks the command sequencer to carry the refresh out. A free-running interval counter marks one owed refresh each average refresh period. Owed refreshes are kept in a small saturating backlog. Before any refresh or self-refresh entry, the block asks the sequencer to precharge all banks and waits for the acknowledge. It then raises a refresh request and waits again. After every refresh, the sequencer may issue nothing until one row cycle time has passed. The block signals this through a command-permit flag.

A sleep input places the memory in self-refresh by driving the clock-enable output low. The request is honoured only once the banks are precharged. Dropping the sleep input raises clock-enable at once. The device registers the exit on the second rising edge after that. The block then waits one row cycle, requests a single refresh, and only after that refresh has settled does it permit commands again. If a period elapses while the backlog is already full, refreshes have been missed. In that case a wake-up burst of at least two refreshes is owed before commands are permitted.

Both handshakes follow valid/ready rules. A request, once raised, stays high until the cycle in which its acknowledge is also high. The sequencer may hold off any request for as long as it needs, and the request waits. That back-pressure delays refreshes, so the backlog grows.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset, clock-enable is high, command-permit is high, sleep-ready is low, and neither the precharge nor the refresh request is raised.
- R2: With both acknowledges given at once, exactly one refresh handshake occurs in every INTERVAL clock cycles (default 1560).
- R3: Every refresh request is preceded by a completed precharge handshake with no command permitted in between. After a refresh handshake in cycle c, command-permit is low through cycle c+TRC-1 (TRC default 7).
- R4: The backlog of owed refreshes saturates at BACKLOG_MAX (default 8). Once the precharge is acknowledged, all owed refreshes are issued back to back with no further precharge request.
- R5: A period that ends while the backlog is full marks the refresh period as exceeded. At least WAKE_REFS refreshes (default 2) are then issued before command-permit returns.
- R6: A sleep request first raises the precharge request while clock-enable stays high. In the cycle after the precharge handshake, clock-enable is low and sleep-ready is high.
- R7: While clock-enable is low, no precharge request, no refresh request and no command permit is raised. The interval counter and backlog are cleared, so only the exit refresh is owed on wake-up.
- R8: Clock-enable rises on the first clock edge at which sleep is seen low. The exit refresh request rises TRC+1 cycles after clock-enable rose.
- R9: Command-permit stays low from self-refresh exit until TRC cycles after the exit refresh handshake.
- R10: A precharge or refresh request that is not acknowledged remains raised in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | High to enter and hold self-refresh |
| sleep_ready | output | 1 | High while the memory is in self-refresh |
| cke | output | 1 | Clock-enable to the memory |
| cmd_permit | output | 1 | Sequencer may issue normal commands |
| pre_req | output | 1 | Precharge-all request (valid) |
| pre_ack | input | 1 | Precharge-all done (ready) |
| ref_req | output | 1 | Auto refresh request (valid) |
| ref_ack | input | 1 | Auto refresh issued (ready) |

## Verification
The properties take for granted that the sequencer raises an acknowledge only while the matching request is high. They also assume the acknowledge cycle is the cycle in which the command is issued. The bench guarantees both by deriving each acknowledge as the request gated by a bench-controlled enable. Back-pressure is modelled by clearing that enable for chosen numbers of whole periods. Sleep requests are applied only while commands are permitted, and are held stable until the exit is wanted.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_REF,
    ST_PRE_SLP,
    ST_REF,
    ST_RWAIT,
    ST_SLEEP,
    ST_XWAIT
  } sched_state_t;
endpackage

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
  parameter int INTERVAL    = 1560,
  parameter int BACKLOG_MAX = 8,
  parameter int WAKE_REFS   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ref_done,
  output logic owed_any,
  output logic wake_pend
);
  localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int OW = $clog2(BACKLOG_MAX + 1);
  localparam int WW = $clog2(WAKE_REFS + 1);

  logic [IW-1:0] ivl_q;
  logic [OW-1:0] owed_q;
  logic [WW-1:0] wake_q;
  logic tick, full, inc, dec, overdue;

  always_comb begin
    tick    = (ivl_q == IW'(INTERVAL - 1));
    full    = (owed_q == OW'(BACKLOG_MAX));
    inc     = tick && (!full || ref_done);
    dec     = ref_done && (owed_q != '0);
    overdue = tick && full && !ref_done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      ivl_q  <= '0;
      owed_q <= '0;
      wake_q <= '0;
    end else begin
      ivl_q <= tick ? '0 : ivl_q + 1'b1;
      if (inc && !dec)
        owed_q <= owed_q + 1'b1;
      else if (dec && !inc)
        owed_q <= owed_q - 1'b1;
      if (overdue)
        wake_q <= WW'(WAKE_REFS);
      else if (ref_done && wake_q != '0)
        wake_q <= wake_q - 1'b1;
    end
  end

  assign owed_any  = (owed_q != '0);
  assign wake_pend = (wake_q != '0);
endmodule

// File: rtl/refresh_delay_timer.sv
module refresh_delay_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/refresh_ctrl_fsm.sv
module refresh_ctrl_fsm
  import sdram_refresh_pkg::*;
#(
  parameter int TRC = 7,
  parameter int TW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_req,
  input  logic          pre_ack,
  input  logic          ref_ack,
  input  logic          owed_any,
  input  logic          wake_pend,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output sched_state_t  state
);
  sched_state_t nxt;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE:
        if (sleep_req)                  nxt = ST_PRE_SLP;
        else if (owed_any || wake_pend) nxt = ST_PRE_REF;
      ST_PRE_REF:
        if (pre_ack) nxt = ST_REF;
      ST_PRE_SLP:
        if (pre_ack) nxt = ST_SLEEP;
      ST_REF:
        if (ref_ack) begin
          nxt      = ST_RWAIT;
          tmr_load = 1'b1;
          tmr_val  = TW'(TRC - 2);
        end
      ST_RWAIT:
        if (tmr_expired) begin
          if (sleep_req)                  nxt = ST_SLEEP;
          else if (owed_any || wake_pend) nxt = ST_REF;
          else                            nxt = ST_IDLE;
        end
      ST_SLEEP:
        if (!sleep_req) begin
          nxt      = ST_XWAIT;
          tmr_load = 1'b1;
          tmr_val  = TW'(TRC);
        end
      ST_XWAIT:
        if (tmr_expired) nxt = ST_REF;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_refresh_pkg::*;
#(
  parameter int INTERVAL    = 1560,
  parameter int BACKLOG_MAX = 8,
  parameter int WAKE_REFS   = 2,
  parameter int TRC         = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic sleep_ready,
  output logic cke,
  output logic cmd_permit,
  output logic pre_req,
  input  logic pre_ack,
  output logic ref_req,
  input  logic ref_ack
);
  localparam int TW = $clog2(TRC + 1);

  sched_state_t  state;
  logic          owed_any, wake_pend, ref_done;
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;

  assign ref_done = ref_req && ref_ack;

  refresh_backlog #(
    .INTERVAL(INTERVAL), .BACKLOG_MAX(BACKLOG_MAX), .WAKE_REFS(WAKE_REFS)
  ) u_backlog (
    .clk(clk), .rst_n(rst_n), .run(cke), .ref_done(ref_done),
    .owed_any(owed_any), .wake_pend(wake_pend)
  );

  refresh_delay_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  refresh_ctrl_fsm #(.TRC(TRC), .TW(TW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .pre_ack(pre_ack),
    .ref_ack(ref_ack), .owed_any(owed_any), .wake_pend(wake_pend),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .state(state)
  );

  assign pre_req     = (state == ST_PRE_REF) || (state == ST_PRE_SLP);
  assign ref_req     = (state == ST_REF);
  assign cke         = (state != ST_SLEEP);
  assign sleep_ready = (state == ST_SLEEP);
  assign cmd_permit  = (state == ST_IDLE) && !wake_pend;
endmodule

// File: rtl/refresh_sched_checker.sv
module refresh_sched_checker #(
  parameter int TRC = 7
) (
  input logic clk,
  input logic rst_n,
  input logic sleep_ready,
  input logic cke,
  input logic cmd_permit,
  input logic pre_req,
  input logic pre_ack,
  input logic ref_req,
  input logic ref_ack
);
  logic [15:0] since_ref, since_cke;
  logic        cke_q, exiting, precharged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_ref  <= 16'hFFFF;
      since_cke  <= 16'hFFFF;
      cke_q      <= 1'b1;
      exiting    <= 1'b0;
      precharged <= 1'b0;
    end else begin
      cke_q <= cke;
      if (ref_req && ref_ack)      since_ref <= '0;
      else if (since_ref != 16'hFFFF) since_ref <= since_ref + 1'b1;
      if (cke && !cke_q) begin
        since_cke <= '0;
        exiting   <= 1'b1;
      end else begin
        if (since_cke != 16'hFFFF) since_cke <= since_cke + 1'b1;
        if (ref_req && ref_ack) exiting <= 1'b0;
      end
      if (pre_req && pre_ack) precharged <= 1'b1;
      else if (cmd_permit)    precharged <= 1'b0;
    end
  end

  assert_ref_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack) |=> ref_req);
  assert_pre_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_req && !pre_ack) |=> pre_req);
  assert_ref_after_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> precharged);
  assert_permit_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_permit |-> (since_ref >= 16'(TRC - 1)));
  assert_sleep_after_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> precharged);
  assert_quiet_asleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!ref_req && !pre_req && !cmd_permit && sleep_ready));
  assert_exit_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exiting && ref_req) |-> (since_cke >= 16'(TRC)));
  assert_permit_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_permit |-> !exiting);
endmodule

bind sdram_refresh_sched refresh_sched_checker #(.TRC(TRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_ready(sleep_ready), .cke(cke),
  .cmd_permit(cmd_permit), .pre_req(pre_req), .pre_ack(pre_ack),
  .ref_req(ref_req), .ref_ack(ref_ack)
);

// File: tb/sdram_refresh_sched_test.sv
`timescale 1ns/1ps
module sdram_refresh_sched_test;
  localparam int IVL  = 40;
  localparam int BMAX = 1;
  localparam int WAKE = 2;
  localparam int TRC  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic pre_en = 1'b1, ref_en = 1'b1;
  logic sleep_ready, cke, cmd_permit, pre_req, pre_ack, ref_req, ref_ack;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign pre_ack = pre_req & pre_en;
  assign ref_ack = ref_req & ref_en;

  sdram_refresh_sched #(
    .INTERVAL(IVL), .BACKLOG_MAX(BMAX), .WAKE_REFS(WAKE), .TRC(TRC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_ready(sleep_ready),
    .cke(cke), .cmd_permit(cmd_permit), .pre_req(pre_req), .pre_ack(pre_ack),
    .ref_req(ref_req), .ref_ack(ref_ack)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ref();
    for (int i = 0; i < 4 * IVL && !(ref_req && ref_ack); i++) step();
  endtask

  task automatic wait_permit();
    for (int i = 0; i < 4 * IVL && !cmd_permit; i++) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, viol, gap;
    bit seen;
    repeat (3) step();
    // R1 reset state
    chk(cke && cmd_permit && !sleep_ready && !pre_req && !ref_req, "R1",
        {cke, cmd_permit, sleep_ready, pre_req, ref_req}, 5'b11000);
    rst_n = 1'b1;

    // R2 periodic refresh
    wait_ref();
    n = 0;
    for (int i = 0; i < 10 * IVL; i++) begin
      step();
      if (ref_req && ref_ack) n++;
    end
    chk(n == 10, "R2", n, 10);

    // R3 permit gap after refresh
    wait_ref();
    viol = 0;
    for (int i = 1; i < TRC; i++) begin
      step();
      if (cmd_permit) viol++;
    end
    step();
    chk(viol == 0, "R3 permit during gap", viol, 0);
    chk(cmd_permit == 1'b1, "R3 permit after gap", cmd_permit, 1);

    // R4/R5 backlog saturation and wake burst sweep
    for (int k = 0; k <= 4; k++) begin
      int exp_refs;
      exp_refs = (k == 0) ? 0 : (k <= BMAX) ? k : ((BMAX > WAKE) ? BMAX : WAKE);
      wait_ref();
      wait_permit();
      pre_en = 1'b0;
      seen = 1'b0;
      for (int i = 0; i < k * IVL; i++) begin
        step();
        if (ref_req) seen = 1'b1;
      end
      pre_en = 1'b1;
      n = 0;
      viol = 0;
      for (int i = 0; i < 25; i++) begin
        step();
        if (ref_req && ref_ack) n++;
        if (pre_req && n > 0) viol++;
      end
      chk(!seen, "R3 no refresh before precharge", seen, 0);
      chk(n == exp_refs, (k > BMAX) ? "R5 wake burst count" : "R4 backlog count",
          n, exp_refs);
      chk(viol == 0, "R4 back-to-back without precharge", viol, 0);
      chk(cmd_permit == 1'b1, "R4 permit after drain", cmd_permit, 1);
    end

    // R6 sleep entry waits for precharge
    wait_ref();
    wait_permit();
    pre_en = 1'b0;
    sleep_req = 1'b1;
    viol = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      if (!(pre_req && cke && !sleep_ready)) viol++;
    end
    chk(viol == 0, "R6 precharge before sleep", viol, 0);
    pre_en = 1'b1;
    step();
    chk(!cke && sleep_ready, "R6 sleep entered", {cke, sleep_ready}, 2'b01);

    // R7 quiet while asleep
    viol = 0;
    for (int i = 0; i < 3 * IVL; i++) begin
      step();
      if (ref_req || pre_req || cmd_permit || cke) viol++;
    end
    chk(viol == 0, "R7 quiet asleep", viol, 0);

    // R8 exit timing
    sleep_req = 1'b0;
    step();
    chk(cke && !sleep_ready, "R8 cke rises", {cke, sleep_ready}, 2'b10);
    n = 0;
    viol = 0;
    while (!ref_req && n < 50) begin
      step();
      n++;
      if (cmd_permit) viol++;
    end
    chk(n == TRC + 1, "R8 exit refresh delay", n, TRC + 1);

    // R9 permit held until exit refresh settles
    gap = 0;
    while (!cmd_permit && gap < 50) begin
      step();
      gap++;
    end
    chk(viol == 0, "R9 no permit before exit refresh", viol, 0);
    chk(gap == TRC, "R9 permit after exit refresh", gap, TRC);

    // R7 backlog cleared by sleep
    n = 0;
    for (int i = 0; i < IVL - 2 * TRC - 5; i++) begin
      step();
      if (ref_req) n++;
    end
    chk(n == 0, "R7 no stale backlog", n, 0);

    // R10 request held under back-pressure
    wait_permit();
    ref_en = 1'b0;
    wait_ref();
    for (int i = 0; i < 4 * IVL && !ref_req; i++) step();
    viol = 0;
    for (int i = 0; i < 6; i++) begin
      step();
      if (!ref_req) viol++;
    end
    chk(viol == 0, "R10 refresh request held", viol, 0);
    ref_en = 1'b1;
    step();
    chk(!ref_req && !cmd_permit, "R10 request drops after ack",
        {ref_req, cmd_permit}, 2'b00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule